// File: doc/BRIEF.md
# USB Low-Speed Packet Receiver

This block takes the raw D+ and D- lines of a low-speed USB link (1.5 Mbit/s), clocked by a 16 MHz system clock, and turns each incoming packet into a stream of bytes. It synchronises both lines into the clock domain. It then locks onto the sync pattern by restarting its bit timer on every J-to-K transition. It samples each bit near its centre, using a fractional timer that spaces samples 10, 11 and 11 clocks apart, so three bits take exactly 32 clocks.

After the closing pair of K bits in the sync field, the block decodes NRZI and discards the bit that follows every run of six ones. It packs the bits LSB first into bytes and delivers each byte as a one-cycle pulse on `byte_valid`. A single-ended zero seen at a sample point ends the packet. The block then raises `pkt_end` for one cycle, together with a status code and the number of bytes delivered.

The byte output carries valid only, with no ready. The bus cannot be paused, so the consumer must accept every pulse in the cycle it appears. PID checking, CRC checking and transaction handling belong to later stages.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset `byte_valid`, `pkt_end`, `pkt_status` and `pkt_len` are 0. While the line idles in J (D+ low, D- high), no pulse appears on either output.
- R2: The receiver enters sync search on a J-to-K transition (K = D+ high, D- low). Each J-to-K transition during the search restarts the bit timer. The first sample falls 5 clocks after the restart, and later samples follow at 10, 11, 11 clock spacing (32 clocks per 3 bits), with no further restarts while data is received. Multi-byte packets must therefore decode without error.
- R3: Sync lock happens only when two consecutive samples are both K. A K sample followed by a J sample keeps the search going, so extra K/J pairs before the sync field do not disturb reception.
- R4: During the search, if no J-to-K transition arrives for SYNC_LIMIT clocks and no lock occurs, `pkt_end` pulses with `pkt_status` = 2 and `pkt_len` = 0, and the receiver returns to idle.
- R5: In NRZI decoding, a sample whose D- level equals the previous sample's decodes as 1, and a change decodes as 0. The first data sample is compared against the closing K of the sync field. Bytes are assembled LSB first and each one is presented for one cycle with `byte_valid` high.
- R6: After six consecutive decoded 1s, the next sample is discarded and does not count toward the byte. The closing K of the sync field counts as the first 1 of such a run.
- R7: A sample with both lines low (SE0) ends the packet: `pkt_end` pulses with `pkt_status` = 0 and `pkt_len` equal to the number of bytes delivered. Bits of an unfinished byte are dropped. A new packet is accepted only after the line has returned to J.
- R8: Completing byte number BUF_BYTES+1 delivers no byte. Instead `pkt_end` pulses with `pkt_status` = 1 and `pkt_len` = BUF_BYTES, and the rest of the packet is ignored until SE0 and then J.
- R9: `byte_valid` and `pkt_end` are never high in the same cycle, and `byte_valid` occurs only while a packet is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_in | input | 1 | Raw D+ line level |
| dm_in | input | 1 | Raw D- line level |
| byte_valid | output | 1 | One-cycle pulse: `byte_data` holds a received byte |
| byte_data | output | 8 | Received byte, first bit on the wire in bit 0 |
| pkt_end | output | 1 | One-cycle pulse at the end of a packet or search |
| pkt_status | output | 2 | 0 ok, 1 overflow, 2 sync timeout; held until the next end |
| pkt_len | output | clog2(BUF_BYTES+1) | Bytes delivered in the packet; held until the next end |

## Verification
The assertions check, on every cycle, the spacing of the sample strobes after a restart and between samples. They also check that a discarded bit always follows a delivered 1 and is never followed directly by another discard. Finally, they check that the reported length equals the count of byte pulses, that a timeout reports no bytes, and that the byte and end pulses stay exclusive. Whether a byte's value is right depends on NRZI decoding, unstuffing and fractional timing acting together, which only the bench's driven packets can show. The same holds for lock on the double K after stray K/J pairs, overflow truncation and timeout latency.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;
  typedef enum logic [1:0] {
    RX_OK           = 2'd0,
    RX_OVERFLOW     = 2'd1,
    RX_SYNC_TIMEOUT = 2'd2
  } rx_status_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HUNT = 3'd1,
    PH_DATA = 3'd2,
    PH_SKIP = 3'd3,
    PH_EOP  = 3'd4
  } rx_phase_e;
endpackage

// File: rtl/usb_ls_line_sync.sv
module usb_ls_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_raw,
  input  logic dm_raw,
  output logic dp_s,
  output logic dm_s
);
  logic [STAGES-1:0] dp_q;
  logic [STAGES-1:0] dm_q;

  // Reset to the J (idle) levels so no false edge follows reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q <= '0;
      dm_q <= '1;
    end else begin
      dp_q <= {dp_q[STAGES-2:0], dp_raw};
      dm_q <= {dm_q[STAGES-2:0], dm_raw};
    end
  end

  assign dp_s = dp_q[STAGES-1];
  assign dm_s = dm_q[STAGES-1];
endmodule

// File: rtl/usb_ls_bit_timer.sv
module usb_ls_bit_timer #(
  parameter int CLK_NUM = 32,
  parameter int BIT_DEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic run,
  output logic strobe
);
  localparam int BASE = CLK_NUM / BIT_DEN;
  localparam int REM  = CLK_NUM % BIT_DEN;
  localparam int HALF = CLK_NUM / (2 * BIT_DEN);
  localparam int CW   = $clog2(BASE + 1);
  localparam int AW   = $clog2(BIT_DEN + 1);

  logic [CW-1:0] cnt;
  logic          stretch;

  assign strobe = run && !reload && (cnt == '0);

  generate
    if (REM == 0) begin : g_integer
      assign stretch = 1'b0;
    end else begin : g_fraction
      logic [AW-1:0] acc;
      logic [AW:0]   acc_sum;
      assign acc_sum = {1'b0, acc} + (AW+1)'(REM);
      assign stretch = acc_sum >= (AW+1)'(BIT_DEN);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc <= '0;
        else if (reload) acc <= '0;
        else if (strobe) acc <= stretch ? AW'(acc_sum - (AW+1)'(BIT_DEN)) : AW'(acc_sum);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (reload)     cnt <= CW'(HALF - 1);
    else if (strobe)     cnt <= stretch ? CW'(BASE) : CW'(BASE - 1);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  // Checker state: clocks since the last restart or strobe.
  logic [CW:0] gap;
  logic        armed;
  logic        from_reload;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; armed <= 1'b0; from_reload <= 1'b0;
    end else if (reload) begin
      gap <= (CW+1)'(1); armed <= 1'b1; from_reload <= 1'b1;
    end else if (strobe) begin
      gap <= (CW+1)'(1); from_reload <= 1'b0;
    end else if (gap != '1) begin
      gap <= gap + (CW+1)'(1);
    end
  end

  assert_half_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && armed && from_reload) |-> (gap == (CW+1)'(HALF)));
  assert_bit_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && armed && !from_reload) |-> (gap == (CW+1)'(BASE) || gap == (CW+1)'(BASE + 1)));
endmodule

// File: rtl/usb_ls_unstuff.sv
module usb_ls_unstuff #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] ones;
  logic          at_run;

  assign at_run    = ones == RW'(RUN_LEN);
  assign out_valid = in_valid && !at_run;
  assign out_bit   = in_bit;

  // The closing sync K decodes as a 1 and opens the first run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ones <= '0;
    else if (start)    ones <= RW'(1);
    else if (in_valid) ones <= (at_run || !in_bit) ? '0 : ones + RW'(1);
  end

  logic last_drop;
  logic last_one;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_drop <= 1'b0; last_one <= 1'b0;
    end else if (start) begin
      last_drop <= 1'b0; last_one <= 1'b1;
    end else if (in_valid) begin
      last_drop <= !out_valid;
      if (out_valid) last_one <= in_bit;
    end
  end

  assert_no_double_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last_drop) |-> out_valid);
  assert_drop_after_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !out_valid) |-> last_one);
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int BUF_BYTES   = 8,
  parameter int SYNC_LIMIT  = 32,
  parameter int CLK_NUM     = 32,
  parameter int BIT_DEN     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int RUN_LEN     = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dp_in,
  input  logic                           dm_in,
  output logic                           byte_valid,
  output logic [7:0]                     byte_data,
  output logic                           pkt_end,
  output logic [1:0]                     pkt_status,
  output logic [$clog2(BUF_BYTES+1)-1:0] pkt_len
);
  localparam int LW = $clog2(BUF_BYTES + 1);
  localparam int TW = $clog2(SYNC_LIMIT + 1);

  logic dp_s, dm_s, dm_d;
  logic is_k, is_j, is_se0;
  rx_phase_e phase;
  logic edge_jk, reload, run, strobe;
  logic hunt_k, lock, timeout;
  logic [TW-1:0] hunt_tmr;
  logic last_dm, bit_valid, nrzi_bit, ub_valid, ub_bit;
  logic [7:0] shreg, full_byte;
  logic [2:0] bitcnt;
  logic [LW-1:0] nbytes;
  logic byte_done, buf_full;

  usb_ls_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .dp_raw(dp_in), .dm_raw(dm_in), .dp_s(dp_s), .dm_s(dm_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dm_d <= 1'b1;
    else        dm_d <= dm_s;
  end

  assign is_k    = dp_s & ~dm_s;
  assign is_j    = ~dp_s & dm_s;
  assign is_se0  = ~dp_s & ~dm_s;
  assign edge_jk = dm_d & is_k;
  assign reload  = edge_jk && (phase == PH_IDLE || phase == PH_HUNT);
  assign run     = (phase == PH_HUNT) || (phase == PH_DATA);

  usb_ls_bit_timer #(.CLK_NUM(CLK_NUM), .BIT_DEN(BIT_DEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .reload(reload), .run(run), .strobe(strobe)
  );

  assign lock      = (phase == PH_HUNT) && strobe && is_k && hunt_k;
  assign timeout   = (phase == PH_HUNT) && !reload && !lock && (hunt_tmr == TW'(SYNC_LIMIT));
  assign bit_valid = (phase == PH_DATA) && strobe && !is_se0;
  assign nrzi_bit  = (dm_s == last_dm);

  usb_ls_unstuff #(.RUN_LEN(RUN_LEN)) u_unstuff (
    .clk(clk), .rst_n(rst_n), .start(lock), .in_valid(bit_valid), .in_bit(nrzi_bit),
    .out_valid(ub_valid), .out_bit(ub_bit)
  );

  assign full_byte = {ub_bit, shreg[7:1]};
  assign byte_done = ub_valid && (bitcnt == 3'd7);
  assign buf_full  = (nbytes == LW'(BUF_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      hunt_k     <= 1'b0;
      hunt_tmr   <= '0;
      last_dm    <= 1'b0;
      shreg      <= '0;
      bitcnt     <= '0;
      nbytes     <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      pkt_end    <= 1'b0;
      pkt_status <= RX_OK;
      pkt_len    <= '0;
    end else begin
      byte_valid <= 1'b0;
      pkt_end    <= 1'b0;
      unique case (phase)
        PH_IDLE: if (reload) begin
          phase    <= PH_HUNT;
          hunt_k   <= 1'b0;
          hunt_tmr <= '0;
        end
        PH_HUNT: begin
          if (lock) begin
            phase   <= PH_DATA;
            last_dm <= 1'b0;
            bitcnt  <= '0;
            nbytes  <= '0;
          end else if (timeout) begin
            phase      <= PH_IDLE;
            pkt_end    <= 1'b1;
            pkt_status <= RX_SYNC_TIMEOUT;
            pkt_len    <= '0;
          end else begin
            if (reload) hunt_tmr <= '0;
            else if (hunt_tmr != TW'(SYNC_LIMIT)) hunt_tmr <= hunt_tmr + TW'(1);
            if (strobe) hunt_k <= is_k;
          end
        end
        PH_DATA: if (strobe) begin
          if (is_se0) begin
            phase      <= PH_EOP;
            pkt_end    <= 1'b1;
            pkt_status <= RX_OK;
            pkt_len    <= nbytes;
          end else begin
            last_dm <= dm_s;
            if (ub_valid) begin
              shreg  <= full_byte;
              bitcnt <= bitcnt + 3'd1;
              if (byte_done) begin
                if (buf_full) begin
                  phase      <= PH_SKIP;
                  pkt_end    <= 1'b1;
                  pkt_status <= RX_OVERFLOW;
                  pkt_len    <= nbytes;
                end else begin
                  byte_valid <= 1'b1;
                  byte_data  <= full_byte;
                  nbytes     <= nbytes + LW'(1);
                end
              end
            end
          end
        end
        PH_SKIP: if (is_se0) phase <= PH_EOP;
        PH_EOP:  if (is_j) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Checker: byte pulses since the last end pulse.
  logic [LW:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen <= '0;
    else if (pkt_end)    seen <= '0;
    else if (byte_valid) seen <= seen + (LW+1)'(1);
  end

  assert_len_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> ({1'b0, pkt_len} == seen));
  assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> (pkt_len <= LW'(BUF_BYTES)));
  assert_timeout_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && pkt_status == RX_SYNC_TIMEOUT) |-> (pkt_len == '0));
  assert_pulse_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && pkt_end));
  assert_valid_in_packet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> ($past(phase) == PH_DATA));
endmodule

// File: tb/usb_ls_rx_test.sv
module usb_ls_rx_test;
  localparam int BUF   = 4;
  localparam int LIMIT = 32;
  localparam logic [1:0] SJ = 2'b01;
  localparam logic [1:0] SK = 2'b10;
  localparam logic [1:0] S0 = 2'b00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0;
  logic dm = 1'b1;
  logic byte_valid, pkt_end;
  logic [7:0] byte_data;
  logic [1:0] pkt_status;
  logic [$clog2(BUF+1)-1:0] pkt_len;

  always #2 clk = ~clk;

  usb_ls_rx #(.BUF_BYTES(BUF), .SYNC_LIMIT(LIMIT)) uut (
    .clk(clk), .rst_n(rst_n), .dp_in(dp), .dm_in(dm),
    .byte_valid(byte_valid), .byte_data(byte_data), .pkt_end(pkt_end),
    .pkt_status(pkt_status), .pkt_len(pkt_len)
  );

  int checks = 0;
  int failures = 0;
  int got_n = 0;
  int end_n = 0;
  int both_n = 0;
  logic [7:0] got [0:15];
  logic [7:0] pkt_bytes [0:7];
  logic [1:0] sym [0:255];
  int nsym;
  logic [1:0] cur;
  int ones;
  bit finished = 0;

  always @(negedge clk) begin
    if (byte_valid) begin
      if (got_n < 16) got[got_n] = byte_data;
      got_n++;
    end
    if (pkt_end) end_n++;
    if (byte_valid && pkt_end) both_n++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] s);
    sym[nsym] = s;
    nsym++;
  endtask

  task automatic emit(input bit b);
    if (!b) cur = (cur == SJ) ? SK : SJ;
    put(cur);
    if (b) begin
      ones++;
      if (ones == 6) begin
        cur = (cur == SJ) ? SK : SJ;
        put(cur);
        ones = 0;
      end
    end else ones = 0;
  endtask

  task automatic build(input int nb, input int extra_n, input logic [7:0] extra_val, input int prefix);
    nsym = 0;
    for (int p = 0; p < prefix; p++) begin put(SK); put(SJ); end
    cur = SJ; ones = 0;
    for (int i = 0; i < 8; i++) emit(i == 7);
    for (int b = 0; b < nb; b++)
      for (int i = 0; i < 8; i++) emit(pkt_bytes[b][i]);
    for (int i = 0; i < extra_n; i++) emit(extra_val[i]);
    put(S0); put(S0); put(SJ);
  endtask

  task automatic drive();
    got_n = 0; end_n = 0;
    for (int k = 0; k < nsym; k++) begin
      {dp, dm} = sym[k];
      repeat (((k + 1) * 32) / 3 - (k * 32) / 3) @(negedge clk);
    end
    {dp, dm} = SJ;
    repeat (40) @(negedge clk);
  endtask

  task automatic expect_pkt(input int nb, input int st, input int len, input string req);
    check(end_n == 1, req, "end pulse count", end_n, 1);
    check(pkt_status == 2'(st), req, "status", int'(pkt_status), st);
    check(pkt_len == 3'(len), req, "length", int'(pkt_len), len);
    check(got_n == nb, req, "bytes delivered", got_n, nb);
    for (int i = 0; i < nb && i < got_n; i++)
      check(got[i] == pkt_bytes[i], req, $sformatf("byte %0d", i), int'(got[i]), int'(pkt_bytes[i]));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(byte_valid == 1'b0, "R1", "byte_valid in reset", int'(byte_valid), 0);
    check(pkt_end == 1'b0, "R1", "pkt_end in reset", int'(pkt_end), 0);
    check(pkt_status == 2'd0, "R1", "status in reset", int'(pkt_status), 0);
    check(pkt_len == '0, "R1", "length in reset", int'(pkt_len), 0);
    rst_n = 1'b1;
    got_n = 0; end_n = 0;
    repeat (60) @(negedge clk);
    check(got_n == 0 && end_n == 0, "R1", "pulses while idle", got_n + end_n, 0);

    // R5 R6: every single-byte value.
    for (int v = 0; v < 256; v++) begin
      pkt_bytes[0] = 8'(v);
      build(1, 0, 8'h00, 0);
      drive();
      expect_pkt(1, 0, 1, "R5 R6");
    end

    // R2 R7: full buffer, mixed patterns, no resync during data.
    pkt_bytes[0] = 8'h00; pkt_bytes[1] = 8'hFF; pkt_bytes[2] = 8'h3F; pkt_bytes[3] = 8'h7E;
    build(4, 0, 8'h00, 0); drive();
    expect_pkt(4, 0, 4, "R2 R7");

    // R6: long runs of ones.
    pkt_bytes[0] = 8'hFF; pkt_bytes[1] = 8'hFF; pkt_bytes[2] = 8'hFF;
    build(3, 0, 8'h00, 0); drive();
    expect_pkt(3, 0, 3, "R6");

    // R7: trailing partial byte is dropped.
    pkt_bytes[0] = 8'h5A; pkt_bytes[1] = 8'hC3;
    build(2, 5, 8'h1F, 0); drive();
    expect_pkt(2, 0, 2, "R7");

    // R8: overflow truncates, then the next packet is received normally.
    pkt_bytes[0] = 8'h11; pkt_bytes[1] = 8'h22; pkt_bytes[2] = 8'h33;
    pkt_bytes[3] = 8'h44; pkt_bytes[4] = 8'h55; pkt_bytes[5] = 8'h66;
    build(6, 0, 8'h00, 0); drive();
    expect_pkt(4, 1, 4, "R8");
    pkt_bytes[0] = 8'hA5;
    build(1, 0, 8'h00, 0); drive();
    expect_pkt(1, 0, 1, "R8");

    // R3: stray K/J pairs ahead of the sync field.
    pkt_bytes[0] = 8'h3C;
    build(1, 0, 8'h00, 2); drive();
    expect_pkt(1, 0, 1, "R3");

    // R3: alternating K/J without a double K never locks.
    nsym = 0;
    put(SK); put(SJ); put(SK); put(SJ);
    for (int i = 0; i < 8; i++) put(SJ);
    drive();
    check(end_n == 1, "R3", "end pulse count", end_n, 1);
    check(pkt_status == 2'd2, "R3", "status", int'(pkt_status), 2);
    check(got_n == 0, "R3", "bytes delivered", got_n, 0);

    // R4: single K then idle; timeout latency and report.
    begin
      int lat;
      bit seen_end;
      got_n = 0; end_n = 0;
      lat = 0; seen_end = 0;
      {dp, dm} = SK;
      while (!seen_end && lat < 200) begin
        @(negedge clk);
        lat++;
        if (pkt_end) seen_end = 1;
        if (lat == 11) {dp, dm} = SJ;
      end
      check(seen_end && lat >= LIMIT + 2 && lat <= LIMIT + 6, "R4", "timeout latency", lat, LIMIT + 4);
      check(pkt_status == 2'd2, "R4", "status", int'(pkt_status), 2);
      check(pkt_len == '0, "R4", "length", int'(pkt_len), 0);
      repeat (40) @(negedge clk);
      check(got_n == 0 && end_n == 1, "R4", "pulses", got_n * 10 + end_n, 1);
    end
    pkt_bytes[0] = 8'h96;
    build(1, 0, 8'h00, 0); drive();
    expect_pkt(1, 0, 1, "R4");

    check(both_n == 0, "R9", "cycles with byte and end together", both_n, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule